// File: doc/BRIEF.md
# Conditional Branch Nesting Controller

This block sequences the program counter of a small shader processor. Every retired instruction is signalled by a step strobe. The block then either advances the PC by one, or acts on a conditional "if" instruction. That instruction compares two condition flags against reference bits, merges the two outcomes, and then either falls into the then-part or jumps to the else-part.

When the condition holds, the block keeps a record of the pending else-region: where it starts and how many instructions it spans. These records sit on a last-in, first-out stack of fixed depth. Once the PC update for a step is done, the new PC is compared with the start address held in the newest record. On a match, the PC jumps past the else-region and that record is discarded.

Regions end by address and length, so no closing opcode is needed. A halt input freezes the whole sequencer. A sticky flag reports an attempt to nest deeper than the stack allows.

Top module: `cond_seq`

## Requirements
- R1: After a synchronous active-low reset, the PC is 0, the overflow flag is 0 and the stack is empty, so no earlier record can cause a skip.
- R2: A step with a non-branch instruction sets the PC to PC+1. With no step, the PC holds.
- R3: While halt is 1, a step has no effect. The PC holds and no record is pushed.
- R4: Each flag is compared for equality with its own reference bit: flag_x with ref_x, and flag_y with ref_y.
- R5: The combine code selects how the two matches are merged: 0 is OR, 1 is AND, 2 uses the X match only, and 3 uses the Y match only.
- R6: When an if passes, a record of {target, skip length} is pushed and the PC becomes PC+1.
- R7: When an if fails, the PC becomes the target and the stack is left as it was.
- R8: After each step's PC update, the newest record is checked. If the stack is non-empty and the new PC equals that record's address, the PC becomes address + length and the record is popped. Only the newest record is checked, once per step.
- R9: A passing if whose target equals PC+1 (an empty then-part) is skipped in the same step. The PC becomes target + length and the stack depth does not change.
- R10: Up to 8 records can be held. A passing if on a full stack drops its record and sets the overflow flag, which stays set until reset.
- R11: Nested records are handled in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | One instruction retires this cycle |
| halt_i | input | 1 | Freezes the sequencer |
| is_if_i | input | 1 | The retiring instruction is a conditional if |
| ref_x_i | input | 1 | Reference bit for flag X |
| ref_y_i | input | 1 | Reference bit for flag Y |
| comb_op_i | input | 2 | Combine code (0 OR, 1 AND, 2 X only, 3 Y only) |
| flag_x_i | input | 1 | Condition flag X |
| flag_y_i | input | 1 | Condition flag Y |
| target_i | input | 12 | Else start address |
| skip_len_i | input | 12 | Number of else instructions |
| pc_o | output | 12 | Program counter after the last step |
| ovf_o | output | 1 | Sticky nesting overflow |

## Verification
The bench targets a failing if whose target lands just short of an open else-region; a design that disturbed the stack on failure would skip at the wrong place or never skip. It targets an empty then-part, which a design that checks only the old top of stack would run into instead of skipping. It pushes past eight records and then unwinds: a design that kept the dropped record, or that cleared the flag, would end on the wrong PC or show a low overflow flag. It also checks that a halted step pushes nothing and that reset clears old records, so a later jump onto a stale address stays there.

// File: rtl/cond_seq_pkg.sv
// Package: shared types for the conditional branch nesting controller.
// Assumes: the combine code is two bits wide and all four values are defined.
package cond_seq_pkg;

    typedef enum logic [1:0] {
        CMB_ANY  = 2'd0,
        CMB_ALL  = 2'd1,
        CMB_X    = 2'd2,
        CMB_Y    = 2'd3
    } comb_op_e;

endpackage

// File: rtl/cond_seq_eval.sv
// Module: cond_seq_eval
// Evaluates the condition of an if instruction. Each flag is matched for
// equality against its reference bit, and the two matches are merged by
// the combine code.
// Assumes: purely combinational, and every input is valid whenever it is used.
module cond_seq_eval
    import cond_seq_pkg::*;
(
    input  logic     [1:0] flag_i,
    input  logic     [1:0] ref_i,
    input  comb_op_e       op_i,
    output logic           ok_o
);

    logic [1:0] match;

    // Per-flag equality match, one slice per flag.
    for (genvar g = 0; g < 2; g++) begin : g_match
        assign match[g] = ~(flag_i[g] ^ ref_i[g]);
    end

    // Merge the two matches according to the combine code.
    always_comb begin
        case (op_i)
            CMB_ANY: ok_o = match[0] | match[1];
            CMB_ALL: ok_o = match[0] & match[1];
            CMB_X:   ok_o = match[0];
            CMB_Y:   ok_o = match[1];
            default: ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cond_seq_stack.sv
// Module: cond_seq_stack
// LIFO of pending else-region records. Each record holds a start address
// and a length. Reset empties the stack and fills every slot with all ones
// as an invalid marker.
// Assumes: the caller never pushes onto a full stack, never pops an empty
// one, and never asserts push and pop in the same cycle.
module cond_seq_stack #(
    parameter int DEPTH = 8,
    parameter int AW    = 12,
    parameter int LW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic [LW-1:0] push_len_i,
    output logic [AW-1:0] top_addr_o,
    output logic [LW-1:0] top_len_o,
    output logic          empty_o,
    output logic          full_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q [DEPTH];
    logic [LW-1:0] len_q  [DEPTH];
    logic [IW-1:0] top_sel;

    assign empty_o = (cnt == '0);
    assign full_o  = (cnt == CW'(DEPTH));

    // Occupancy counter: up on push, down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (push_i)
            cnt <= cnt + CW'(1);
        else if (pop_i)
            cnt <= cnt - CW'(1);
    end

    // One storage slot per entry, written when it is the next free slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[g] <= '1;
                len_q[g]  <= '1;
            end else if (push_i && cnt == CW'(g)) begin
                addr_q[g] <= push_addr_i;
                len_q[g]  <= push_len_i;
            end
        end
    end

    // Select the newest record (slot 0 when empty, which the caller ignores).
    always_comb begin
        top_sel    = empty_o ? '0 : IW'(cnt - CW'(1));
        top_addr_o = addr_q[top_sel];
        top_len_o  = len_q[top_sel];
    end

    a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && full_o));
    a_r11_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && empty_o));
    a_r11_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (top_addr_o == $past(push_addr_i) && top_len_o == $past(push_len_i)));
    a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/cond_seq.sv
// Module: cond_seq (top)
// Program-counter sequencer for conditional if instructions. On each
// retired step it computes the base PC: PC+1, or the target when an if
// fails. A passing if pushes a record; a push onto a full stack is dropped
// and sets a sticky overflow flag. The base PC is then checked against the
// newest record, which is either the one pushed in this step or the current
// top. On a match the PC jumps past the else-region and the record is
// popped; a push and a pop in the same step cancel each other.
// Assumes: LEN_W <= PC_W, and the PC wraps modulo 2**PC_W.
module cond_seq
    import cond_seq_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int LEN_W = 12,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             halt_i,
    input  logic             is_if_i,
    input  logic             ref_x_i,
    input  logic             ref_y_i,
    input  logic [1:0]       comb_op_i,
    input  logic             flag_x_i,
    input  logic             flag_y_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic [LEN_W-1:0] skip_len_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             ovf_o
);

    logic [PC_W-1:0]  pc_q;
    logic             ovf_q;
    logic             step_en;
    logic             cond_ok;
    comb_op_e         op_e;
    logic             stk_push, stk_pop, stk_empty, stk_full;
    logic [PC_W-1:0]  top_addr;
    logic [LEN_W-1:0] top_len;
    logic             want_push, accept;
    logic             eff_valid, hit;
    logic [PC_W-1:0]  base_pc, eff_addr, nxt_pc;
    logic [LEN_W-1:0] eff_len;

    assign op_e    = comb_op_e'(comb_op_i);
    assign step_en = step_i && !halt_i;

    cond_seq_eval i_eval (
        .flag_i ({flag_y_i, flag_x_i}),
        .ref_i  ({ref_y_i, ref_x_i}),
        .op_i   (op_e),
        .ok_o   (cond_ok)
    );

    cond_seq_stack #(.DEPTH(DEPTH), .AW(PC_W), .LW(LEN_W)) i_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (stk_push),
        .pop_i       (stk_pop),
        .push_addr_i (target_i),
        .push_len_i  (skip_len_i),
        .top_addr_o  (top_addr),
        .top_len_o   (top_len),
        .empty_o     (stk_empty),
        .full_o      (stk_full)
    );

    // Next-PC selection, end-of-else detection and stack control.
    always_comb begin
        want_push = step_en && is_if_i && cond_ok;
        accept    = want_push && !stk_full;
        base_pc   = (is_if_i && !cond_ok) ? target_i : pc_q + PC_W'(1);
        eff_valid = accept || !stk_empty;
        eff_addr  = accept ? target_i   : top_addr;
        eff_len   = accept ? skip_len_i : top_len;
        hit       = step_en && eff_valid && (base_pc == eff_addr);
        nxt_pc    = hit ? base_pc + PC_W'(eff_len) : base_pc;
        stk_push  = accept && !hit;
        stk_pop   = hit && !accept;
    end

    // PC register: updates once per enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (step_en)
            pc_q <= nxt_pc;
    end

    // Sticky overflow: set by a passing if on a full stack.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (want_push && stk_full)
            ovf_q <= 1'b1;
    end

    assign pc_o  = pc_q;
    assign ovf_o = ovf_q;

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    a_r3_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> $stable(pc_o));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(pc_o));
    a_r7_fail_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && is_if_i && !cond_ok && stk_empty) |=> (pc_o == $past(target_i)));
    a_r2_plain_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !is_if_i && stk_empty) |=> (pc_o == $past(pc_o) + PC_W'(1)));

endmodule

// File: tb/test_cond_seq.sv
`timescale 1ns/100ps
module test_cond_seq;

    typedef struct packed {
        logic        is_if;
        logic        rx;
        logic        ry;
        logic [1:0]  op;
        logic        fx;
        logic        fy;
        logic [11:0] tgt;
        logic [11:0] len;
        logic [11:0] exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h001}, // R2 plain step
        '{1'b1,1'b1,1'b1,2'd0,1'b0,1'b0,12'h020,12'h000,12'h020}, // R4 R5 R7 OR, both miss
        '{1'b1,1'b1,1'b0,2'd1,1'b1,1'b0,12'h025,12'h003,12'h021}, // R6 AND, both match
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h022}, // R2
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h023}, // R2
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h024}, // R2
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h028}, // R8 skip else
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h029}, // R8 popped
        '{1'b1,1'b0,1'b1,2'd2,1'b0,1'b0,12'h030,12'h002,12'h02A}, // R5 X only pass
        '{1'b1,1'b0,1'b1,2'd3,1'b0,1'b0,12'h02C,12'h000,12'h02C}, // R5 Y only fail, R7
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h02D}, // R2
        '{1'b1,1'b1,1'b0,2'd0,1'b1,1'b1,12'h02E,12'h001,12'h02F}, // R9 empty then-part
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h032}, // R8 R7 outer kept
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h033}, // R2
        '{1'b1,1'b1,1'b1,2'd1,1'b1,1'b0,12'h050,12'h000,12'h050}, // R5 AND fail
        '{1'b1,1'b0,1'b0,2'd0,1'b1,1'b0,12'h060,12'h005,12'h051}, // R5 OR one match
        '{1'b1,1'b0,1'b1,2'd3,1'b0,1'b1,12'h053,12'h002,12'h052}, // R11 nested push
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h055}, // R11 inner pop
        '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b1,12'h05F,12'h000,12'h05F}, // R5 X only fail
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h065}, // R11 outer pop
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,12'h000,12'h000,12'h066}  // R8 empty now
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0, halt_i = 1'b0, is_if_i = 1'b0;
    logic        ref_x_i = 1'b0, ref_y_i = 1'b0, flag_x_i = 1'b0, flag_y_i = 1'b0;
    logic [1:0]  comb_op_i = 2'd0;
    logic [11:0] target_i = '0, skip_len_i = '0;
    logic [11:0] pc_o;
    logic        ovf_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cond_seq i_cond_seq (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .halt_i(halt_i),
        .is_if_i(is_if_i), .ref_x_i(ref_x_i), .ref_y_i(ref_y_i),
        .comb_op_i(comb_op_i), .flag_x_i(flag_x_i), .flag_y_i(flag_y_i),
        .target_i(target_i), .skip_len_i(skip_len_i), .pc_o(pc_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle of inputs, then return after the edge with step cleared.
    task automatic apply(input logic st, input logic hl, input logic isif,
                         input logic rx, input logic ry, input logic [1:0] op,
                         input logic fx, input logic fy,
                         input logic [11:0] tgt, input logic [11:0] len);
        step_i = st; halt_i = hl; is_if_i = isif;
        ref_x_i = rx; ref_y_i = ry; comb_op_i = op;
        flag_x_i = fx; flag_y_i = fy; target_i = tgt; skip_len_i = len;
        @(negedge clk);
        step_i = 1'b0; halt_i = 1'b0; is_if_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset pc", pc_o, 12'h000);
        chk("R1 reset ovf", {11'b0, ovf_o}, 12'h000);

        for (int i = 0; i < NV; i++) begin
            apply(1'b1, 1'b0, VECS[i].is_if, VECS[i].rx, VECS[i].ry, VECS[i].op,
                  VECS[i].fx, VECS[i].fy, VECS[i].tgt, VECS[i].len);
            chk($sformatf("table step %0d (R2 R4-R9 R11)", i), pc_o, VECS[i].exp);
        end

        // R2: no step holds the PC
        @(negedge clk);
        chk("R2 idle hold", pc_o, 12'h066);

        // R3: halted passing if does not move PC or push
        apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 12'h067, 12'h007);
        chk("R3 halt hold", pc_o, 12'h066);
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 12'h000, 12'h000);
        chk("R3 no push while halted", pc_o, 12'h067);

        // R10: fill eight records, then overflow
        for (int k = 0; k < 8; k++)
            apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 12'h200 + 12'(k), 12'h001);
        chk("R10 eight pushes pc", pc_o, 12'h06F);
        chk("R10 no ovf at eight", {11'b0, ovf_o}, 12'h000);
        apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 12'h300, 12'h004);
        chk("R10 ninth push pc", pc_o, 12'h070);
        chk("R10 ovf set", {11'b0, ovf_o}, 12'h001);

        // R11: unwind newest first; dropped record must not exist
        apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 12'h207, 12'h000);
        chk("R11 top record skip", pc_o, 12'h208);
        apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 12'h206, 12'h000);
        chk("R11 next record skip", pc_o, 12'h207);
        chk("R10 ovf sticky", {11'b0, ovf_o}, 12'h001);

        // R1: reset clears flag and stale records
        do_reset();
        chk("R1 reset pc again", pc_o, 12'h000);
        chk("R1 reset clears ovf", {11'b0, ovf_o}, 12'h000);
        apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 12'h205, 12'h000);
        chk("R1 stale record gone", pc_o, 12'h205);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule